// File: doc/BRIEF.md
# Polyphase Interpolating Resampler

This block converts a stream of signed 16-bit samples, arriving one per `in_valid` pulse, into a sparser output stream. A fixed-point phase accumulator records where the next output lies between two input samples. Each time an output is due, the block runs two convolutions over the most recent samples in a small ring buffer. The two coefficient rows it uses are neighbours, chosen by the top bits of the phase. It blends the two results linearly with the remaining phase bits, scales the blend down, clamps it to 16 bits and presents it with a one-cycle `out_valid` strobe.

Both convolutions share one multiplier and run one tap per cycle. `busy` is high while an output is being computed. The rate is set by the 32-bit `step` input, which holds input samples per output with 16 fraction bits. Software or a setup sequencer fills the coefficient rows through a simple write port before streaming starts. The caller spaces input pulses so that none arrives while `busy` is high.

Top module: `poly_resampler`

## Requirements
- R1: While reset is held, `out_valid` and `busy` are low. Reset clears the ring buffer, all coefficients and the phase. The first output after reset therefore starts without any input and equals 0.
- R2: `step` has 16 integer bits (31:16) and 16 fraction bits (15:0). When an output starts, phase + `step` is formed. Its integer part is the number of `in_valid` pulses that must arrive before the next output starts, and its fraction part becomes the new phase.
- R3: The row index k is the top log2(TABLES) bits of the phase. The blend weight w is the rest of the phase shifted left by log2(TABLES), read as a 16-bit unsigned fraction.
- R4: The first sum uses row k. The second uses row k+1. When k is TABLES-1, the second sum uses row 0 and its sample window is one sample newer.
- R5: Let b be the number of samples written when an output starts. Tap j of the first sum multiplies sample b-TAPS-1+j by coefficient j of its row. Samples never written read as 0.
- R6: The result is v1 + ((w*(v2-v1)) >>> 16), then shifted arithmetically right by COEF_SHIFT (8 by default). Both shifts round toward minus infinity.
- R7: The shifted result saturates to the range -32768..32767.
- R8: A new output starts only when no input is still owed and `busy` is low. `out_valid` is a single-cycle pulse.
- R9: `busy` stays high for exactly 2*TAPS+1 cycles per output. `out_valid` rises on the same edge where `busy` falls.
- R10: Coefficient j of row t is written at address t*TAPS+j. A write to an address at or above TAPS*TABLES changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| step | input | 32 | Inputs per output, 16.16 fixed point, read when an output starts |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | $clog2(TAPS*TABLES) | Coefficient address, row*TAPS+tap |
| coef_data | input | 16 | Signed coefficient |
| out_valid | output | 1 | One-cycle output strobe |
| out_sample | output | 16 | Signed saturated output sample |
| busy | output | 1 | Convolution in progress |

## Verification
On every cycle, the assertions check the timing skeleton. The owed-input count never rises between output starts, and the phase holds between starts. The ring pointer moves exactly once per input. `out_valid` is a one-cycle pulse that coincides with the end of a busy period of exactly 2*TAPS+1 cycles. The numeric result can only be shown by the bench's scenarios: row selection, the wrap to row 0 with the shifted window, the blend arithmetic, saturation and ignored coefficient addresses. The bench sweeps several integer and fractional step values, which visits every row index including the wrapping one, and compares each output with a value it computes from the requirements.

// File: rtl/resamp_pkg.sv
package resamp_pkg;

    localparam int SAMPLE_W = 16;
    localparam int STEP_W   = 32;

    typedef enum logic [1:0] {
        MAC_IDLE,
        MAC_FIRST,
        MAC_SECOND,
        MAC_FINISH
    } mac_state_e;

    // Clamp a wide signed value into the signed 16-bit range.
    function automatic logic signed [SAMPLE_W-1:0] clamp16(input logic signed [63:0] v);
        if (v > 64'sd32767) begin
            return 16'sh7fff;
        end else if (v < -64'sd32768) begin
            return 16'sh8000;
        end else begin
            return v[SAMPLE_W-1:0];
        end
    endfunction

endpackage

// File: rtl/resamp_ring.sv
module resamp_ring
    import resamp_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [SAMPLE_W-1:0] wr_data_i,
    input  logic [AW-1:0]       rd_addr_i,
    output logic [SAMPLE_W-1:0] rd_data_o,
    output logic [AW-1:0]       wr_ptr_o
);

    typedef struct packed {
        logic [DEPTH-1:0][SAMPLE_W-1:0] mem;
        logic [AW-1:0]                  ptr;
    } ring_t;

    ring_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.mem[st_q.ptr] = wr_data_i;
            st_d.ptr           = st_q.ptr + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.mem[rd_addr_i];
    assign wr_ptr_o  = st_q.ptr;

    // R5
    wr_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (st_q.ptr == $past(st_q.ptr) + AW'(1)));

    // R5
    wr_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q.ptr));

endmodule

// File: rtl/resamp_coef.sv
module resamp_coef
    import resamp_pkg::*;
#(
    parameter int TAPS   = 5,
    parameter int TABLES = 4,
    parameter int CAW    = $clog2(TAPS*TABLES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [CAW-1:0]      wr_addr_i,
    input  logic [SAMPLE_W-1:0] wr_data_i,
    input  logic [CAW-1:0]      rd_addr_i,
    output logic [SAMPLE_W-1:0] rd_data_o
);

    localparam int ENTRIES = TAPS * TABLES;

    typedef struct packed {
        logic [ENTRIES-1:0][SAMPLE_W-1:0] row;
    } coef_t;

    coef_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (we_i && (wr_addr_i == CAW'(i))) begin
                st_d.row[i] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if ((1 << CAW) == ENTRIES) begin : g_full
            assign rd_data_o = st_q.row[rd_addr_i];
        end else begin : g_part
            assign rd_data_o = (rd_addr_i < CAW'(ENTRIES)) ? st_q.row[rd_addr_i] : '0;
        end
    endgenerate

endmodule

// File: rtl/resamp_phase.sv
module resamp_phase
    import resamp_pkg::*;
#(
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic              start_i,
    input  logic [STEP_W-1:0] step_i,
    output logic              due_zero_o,
    output logic [FRAC_W-1:0] phase_o
);

    localparam int INT_W = STEP_W - FRAC_W;

    typedef struct packed {
        logic [INT_W-1:0]  due;
        logic [FRAC_W-1:0] phase;
    } phase_t;

    phase_t            st_d, st_q;
    logic [STEP_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = STEP_W'(st_q.phase) + step_i;
        if (start_i) begin
            st_d.phase = sum[FRAC_W-1:0];
            st_d.due   = sum[STEP_W-1:FRAC_W];
            if (in_valid_i && (st_d.due != '0)) begin
                st_d.due = st_d.due - INT_W'(1);
            end
        end else if (in_valid_i && (st_q.due != '0)) begin
            st_d.due = st_q.due - INT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign due_zero_o = (st_q.due == '0);
    assign phase_o    = st_q.phase;

    // R2
    due_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (st_q.due <= $past(st_q.due)));

    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(st_q.phase));

endmodule

// File: rtl/resamp_mac.sv
module resamp_mac
    import resamp_pkg::*;
#(
    parameter int TAPS       = 5,
    parameter int TABLES     = 4,
    parameter int DEPTH      = 16,
    parameter int FRAC_W     = 16,
    parameter int COEF_SHIFT = 8,
    parameter int AW         = $clog2(DEPTH),
    parameter int CAW        = $clog2(TAPS*TABLES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [FRAC_W-1:0]   phase_i,
    input  logic [AW-1:0]       base_i,
    output logic [AW-1:0]       ring_addr_o,
    input  logic [SAMPLE_W-1:0] ring_data_i,
    output logic [CAW-1:0]      coef_addr_o,
    input  logic [SAMPLE_W-1:0] coef_data_i,
    output logic                busy_o,
    output logic                out_valid_o,
    output logic [SAMPLE_W-1:0] out_sample_o
);

    localparam int TB    = $clog2(TABLES);
    localparam int JW    = (TAPS > 1) ? $clog2(TAPS) : 1;
    localparam int ACC_W = 2*SAMPLE_W + $clog2(TAPS) + 1;
    localparam int IW    = ACC_W + FRAC_W + 2;
    localparam int CW    = $clog2(2*TAPS + 4) + 1;

    typedef struct packed {
        mac_state_e          state;
        logic [JW-1:0]       tap;
        logic [TB-1:0]       tbl;
        logic [FRAC_W-1:0]   weight;
        logic                wrap;
        logic [AW-1:0]       base;
        logic [ACC_W-1:0]    acc1;
        logic [ACC_W-1:0]    acc2;
        logic                out_valid;
        logic [SAMPLE_W-1:0] out_sample;
    } mac_t;

    mac_t                        st_d, st_q;
    logic                        second;
    logic                        last_tap;
    logic [TB-1:0]               cur_tbl;
    logic signed [2*SAMPLE_W-1:0] prod;
    logic signed [IW-1:0]        diff;
    logic signed [IW-1:0]        wprod;
    logic signed [IW-1:0]        interp;
    logic signed [IW-1:0]        scaled;

    always_comb begin
        second      = (st_q.state == MAC_SECOND);
        cur_tbl     = second ? (st_q.tbl + TB'(1)) : st_q.tbl;
        ring_addr_o = st_q.base - AW'(TAPS + 1) + AW'(st_q.tap) + AW'(second && st_q.wrap);
        coef_addr_o = CAW'(cur_tbl) * CAW'(TAPS) + CAW'(st_q.tap);
        prod        = $signed(ring_data_i) * $signed(coef_data_i);
        last_tap    = (st_q.tap == JW'(TAPS - 1));
        diff        = IW'($signed(st_q.acc2)) - IW'($signed(st_q.acc1));
        wprod       = IW'($signed({1'b0, st_q.weight})) * diff;
        interp      = IW'($signed(st_q.acc1)) + (wprod >>> FRAC_W);
        scaled      = interp >>> COEF_SHIFT;

        st_d           = st_q;
        st_d.out_valid = 1'b0;
        case (st_q.state)
            MAC_IDLE: begin
                if (start_i) begin
                    st_d.state  = MAC_FIRST;
                    st_d.tap    = '0;
                    st_d.tbl    = phase_i[FRAC_W-1 -: TB];
                    st_d.weight = {phase_i[FRAC_W-TB-1:0], {TB{1'b0}}};
                    st_d.wrap   = (phase_i[FRAC_W-1 -: TB] == TB'(TABLES - 1));
                    st_d.base   = base_i;
                    st_d.acc1   = '0;
                    st_d.acc2   = '0;
                end
            end
            MAC_FIRST: begin
                st_d.acc1 = st_q.acc1 + ACC_W'(prod);
                if (last_tap) begin
                    st_d.tap   = '0;
                    st_d.state = MAC_SECOND;
                end else begin
                    st_d.tap = st_q.tap + JW'(1);
                end
            end
            MAC_SECOND: begin
                st_d.acc2 = st_q.acc2 + ACC_W'(prod);
                if (last_tap) begin
                    st_d.tap   = '0;
                    st_d.state = MAC_FINISH;
                end else begin
                    st_d.tap = st_q.tap + JW'(1);
                end
            end
            default: begin
                st_d.out_sample = clamp16(64'(scaled));
                st_d.out_valid  = 1'b1;
                st_d.state      = MAC_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o       = (st_q.state != MAC_IDLE);
    assign out_valid_o  = st_q.out_valid;
    assign out_sample_o = st_q.out_sample;

    // Length of the current busy period, for the latency check.
    logic [CW-1:0] busy_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt_q <= '0;
        end else if (busy_o) begin
            busy_cnt_q <= busy_cnt_q + CW'(1);
        end else begin
            busy_cnt_q <= '0;
        end
    end

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |=> !out_valid_o);

    // R9
    done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> out_valid_o);

    // R9
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_cnt_q == CW'(2*TAPS + 1)));

endmodule

// File: rtl/poly_resampler.sv
module poly_resampler
    import resamp_pkg::*;
#(
    parameter int TAPS       = 5,
    parameter int TABLES     = 4,
    parameter int RING_DEPTH = 16,
    parameter int FRAC_W     = 16,
    parameter int COEF_SHIFT = 8,
    localparam int CAW       = $clog2(TAPS*TABLES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [STEP_W-1:0]   step,
    input  logic                coef_we,
    input  logic [CAW-1:0]      coef_addr,
    input  logic [SAMPLE_W-1:0] coef_data,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                busy
);

    localparam int AW = $clog2(RING_DEPTH);

    logic                start;
    logic                due_zero;
    logic [FRAC_W-1:0]   phase;
    logic [AW-1:0]       wr_ptr;
    logic [AW-1:0]       ring_addr;
    logic [SAMPLE_W-1:0] ring_data;
    logic [CAW-1:0]      rd_coef_addr;
    logic [SAMPLE_W-1:0] rd_coef_data;

    assign start = due_zero && !busy;

    resamp_ring #(.DEPTH(RING_DEPTH), .AW(AW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (in_valid),
        .wr_data_i (in_sample),
        .rd_addr_i (ring_addr),
        .rd_data_o (ring_data),
        .wr_ptr_o  (wr_ptr)
    );

    resamp_coef #(.TAPS(TAPS), .TABLES(TABLES), .CAW(CAW)) u_coef (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (coef_we),
        .wr_addr_i (coef_addr),
        .wr_data_i (coef_data),
        .rd_addr_i (rd_coef_addr),
        .rd_data_o (rd_coef_data)
    );

    resamp_phase #(.FRAC_W(FRAC_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid),
        .start_i    (start),
        .step_i     (step),
        .due_zero_o (due_zero),
        .phase_o    (phase)
    );

    resamp_mac #(
        .TAPS       (TAPS),
        .TABLES     (TABLES),
        .DEPTH      (RING_DEPTH),
        .FRAC_W     (FRAC_W),
        .COEF_SHIFT (COEF_SHIFT),
        .AW         (AW),
        .CAW        (CAW)
    ) u_mac (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .phase_i      (phase),
        .base_i       (wr_ptr),
        .ring_addr_o  (ring_addr),
        .ring_data_i  (ring_data),
        .coef_addr_o  (rd_coef_addr),
        .coef_data_i  (rd_coef_data),
        .busy_o       (busy),
        .out_valid_o  (out_valid),
        .out_sample_o (out_sample)
    );

endmodule

// File: tb/test_poly_resampler.sv
module test_poly_resampler;

    localparam int TAPS   = 5;
    localparam int TABLES = 4;
    localparam int TB     = 2;
    localparam int FRAC   = 16;
    localparam int SHIFT  = 8;
    localparam int CAW    = $clog2(TAPS*TABLES);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [15:0]     in_sample = '0;
    logic [31:0]     step = 32'h0002_0000;
    logic            coef_we = 1'b0;
    logic [CAW-1:0]  coef_addr = '0;
    logic [15:0]     coef_data = '0;
    logic            out_valid;
    logic [15:0]     out_sample;
    logic            busy;

    always #10 clk = ~clk;

    poly_resampler i_poly_resampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .step       (step),
        .coef_we    (coef_we),
        .coef_addr  (coef_addr),
        .coef_data  (coef_data),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .busy       (busy)
    );

    int     checks = 0;
    int     fails  = 0;
    bit     done   = 0;

    int     hist [0:1023];
    int     cnt_m = 0;
    int     coef_m [0:TABLES-1][0:TAPS-1];
    longint due_m = 0;
    longint phase_m = 0;
    int     gidx = 0;

    task automatic check(input string req, input bit ok, input longint got, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, got, expv);
        end
    endtask

    function automatic longint h(input int idx);
        return (idx < 0) ? 0 : longint'(hist[idx]);
    endfunction

    // Expected output from R3..R7 for an output starting with b samples written.
    function automatic longint model(input int b, input longint ph);
        int k, k2, off;
        longint w, v1, v2, v;
        k   = int'(ph >> (FRAC - TB));
        w   = (ph << TB) & 64'hFFFF;
        k2  = (k + 1) % TABLES;
        off = (k + 1 == TABLES) ? 1 : 0;
        v1 = 0;
        v2 = 0;
        for (int j = 0; j < TAPS; j++) begin
            v1 += h(b - TAPS - 1 + j) * coef_m[k][j];
            v2 += h(b - TAPS - 1 + off + j) * coef_m[k2][j];
        end
        v = v1 + ((w * (v2 - v1)) >>> FRAC);
        v = v >>> SHIFT;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return v;
    endfunction

    task automatic advance();
        longint s;
        s       = phase_m + longint'(step);
        phase_m = s & 64'hFFFF;
        due_m   = s >> FRAC;
    endtask

    task automatic wait_out(input string req, input bit want, input longint expv);
        int          seen = 0;
        int          bcyc = 0;
        logic [15:0] got = '0;
        repeat (3*TAPS + 6) begin
            @(negedge clk);
            if (busy) bcyc++;
            if (out_valid) begin
                seen++;
                got = out_sample;
            end
        end
        // R2 R8: exactly one output per owed group of inputs
        check({req, " R2 count"}, seen == (want ? 1 : 0), seen, want ? 1 : 0);
        if (want) begin
            check({req, " value"}, longint'($signed(got)) == expv, longint'($signed(got)), expv);
            // R9: busy period length
            check("R9 busy length", bcyc == 2*TAPS + 1, bcyc, 2*TAPS + 1);
        end else begin
            check("R8 idle busy", bcyc == 0, bcyc, 0);
        end
    endtask

    task automatic push(input int s, input string req);
        bit     want = 0;
        longint e = 0;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 16'(s);
        @(negedge clk);
        in_valid  = 1'b0;
        hist[cnt_m] = s;
        cnt_m++;
        if (due_m > 0) begin
            due_m--;
            if (due_m == 0) begin
                e = model(cnt_m, phase_m);
                advance();
                want = 1;
            end
        end
        wait_out(req, want, e);
    endtask

    task automatic wr_coef(input int addr, input int val);
        @(negedge clk);
        coef_we   = 1'b1;
        coef_addr = CAW'(addr);
        coef_data = 16'(val);
        @(negedge clk);
        coef_we   = 1'b0;
        if (addr < TAPS*TABLES) coef_m[addr / TAPS][addr % TAPS] = val;
    endtask

    function automatic int pattern(input int i);
        return ((i * 2749 + 311) % 8001) - 4000;
    endfunction

    initial begin
        longint steps [6] = '{64'h20000, 64'h24000, 64'h1C000, 64'h2E000, 64'h11000, 64'h32000};
        for (int t = 0; t < TABLES; t++)
            for (int j = 0; j < TAPS; j++) coef_m[t][j] = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", out_valid == 1'b0, out_valid, 0);
        check("R1 busy in reset", busy == 1'b0, busy, 0);
        rst_n = 1'b1;
        // R1: first output comes without input and is zero
        wait_out("R1 first output", 1'b1, 0);
        advance();

        // R10: load rows through the write port, row*TAPS+tap addressing
        for (int a = 0; a < TAPS*TABLES; a++) wr_coef(a, ((a * 97 + 13) % 601) - 300);

        // R3 R4 R5 R6 R11-style sweep over several integer and fractional steps
        foreach (steps[i]) begin
            step = 32'(steps[i]);
            for (int n = 0; n < 14; n++) begin
                push(pattern(gidx), "R3 R4 R5 R6 sweep");
                gidx++;
            end
        end

        // R10: out-of-range coefficient addresses change nothing
        for (int a = TAPS*TABLES; a < (1 << CAW); a++) wr_coef(a, 16'h7abc);
        step = 32'h0001_C000;
        for (int n = 0; n < 10; n++) begin
            push(pattern(gidx), "R10 ignored write");
            gidx++;
        end

        // R7: positive and negative saturation
        for (int a = 0; a < TAPS*TABLES; a++) wr_coef(a, 32767);
        step = 32'h0001_4000;
        for (int n = 0; n < 10; n++) push(32767, "R7 high");
        for (int n = 0; n < 10; n++) push(-32768, "R7 low");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule